// File: doc/BRIEF.md
# One-Hot Traffic Lamp Sequencer

This block drives a three-lamp signal head. Its state register is the lamp drive itself: three flip-flops, one for red, one for yellow and one for green. In normal operation exactly one of them is set. The lit lamp rotates through a fixed order, red then green then yellow, and the sequence repeats without end.

A prescaler divides the fast system clock down to a one-cycle advance pulse. The pulse fires once every `TICK_CYCLES` clock cycles, so each lamp dwells for one second when the parameter equals the clock frequency in hertz. All state changes happen on the rising clock edge, and the three bits update together.

A synchronous reset forces red and restarts the prescaler. If the register ever holds a code that is not one-hot, the sequencer:
- returns to red on the next edge,
- raises a one-cycle fault flag,
- restarts the dwell count.

Top module: `traffic_ring`

## Requirements
- R1: While `rst_i` is high at a rising edge, the next state is `lamp_o` = 3'b100 (red) and `illegal_o` = 0, and the prescaler count is cleared.
- R2: The lamp encoding is `lamp_o[2]` red, `lamp_o[1]` yellow, `lamp_o[0]` green. After reset, and absent corruption, exactly one bit is set on every cycle.
- R3: The advance step sets red from the prior yellow, yellow from the prior green, and green from the prior red. The visible order is therefore 100, 001, 010, 100, and so on.
- R4: Each lamp stays lit for exactly `TICK_CYCLES` clock cycles. The first change away from red comes on the `TICK_CYCLES`-th rising edge after the last edge at which reset was sampled high.
- R5: When the register holds any of 000, 011, 101, 110 or 111 at a rising edge, that edge loads 3'b100 and sets `illegal_o` to 1 for exactly one cycle.
- R6: A recovery clears the prescaler, so red then holds for a full `TICK_CYCLES` cycles before green.
- R7: `illegal_o` is 0 in every cycle other than the one that follows a recovery edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| lamp_o | output | 3 | Lamp drive: [2] red, [1] yellow, [0] green |
| illegal_o | output | 1 | One-cycle pulse after a non-one-hot state was repaired |

## Verification
The bench compares the lamps on every cycle against an arithmetic model, covering the dwell length and the first transition after reset and after each repair. An off-by-one prescaler, or one not cleared by reset, shows up as a change one cycle early or late. A design that shifts the ring the wrong way lights yellow before green.

Each of the five forbidden codes is injected into the state register at several phases of the dwell count. A design that only repairs some codes, or that lets a bad code keep rotating, leaves a non-one-hot or wrong lamp after the edge. A missing, combinational or stretched fault pulse shows up as a wrong `illegal_o` value. Skipping the divider clear on repair shows up as a shortened red.

// File: rtl/traffic_ring_pkg.sv
package traffic_ring_pkg;
   localparam int unsigned LAMP_COUNT = 3;

   // Bit positions inside the lamp vector
   localparam int unsigned RED_BIT    = 2;
   localparam int unsigned YELLOW_BIT = 1;
   localparam int unsigned GREEN_BIT  = 0;

   typedef logic [LAMP_COUNT-1:0] lamp_vec_t;

   localparam lamp_vec_t LAMP_RED = lamp_vec_t'(1) << RED_BIT;

   // True when exactly one lamp bit is set
   function automatic logic is_one_hot(input lamp_vec_t v);
      int unsigned ones;
      ones = 0;
      for (int i = 0; i < LAMP_COUNT; i++) begin
         ones += int'(v[i]);
      end
      return (ones == 1);
   endfunction
endpackage

// File: rtl/tr_tick_gen.sv
module tr_tick_gen #(
   parameter int unsigned TICK_CYCLES = 50_000_000
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic clr_i,
   output logic tick_o
);
   localparam int unsigned CW       = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
   localparam logic [CW-1:0] LAST   = CW'(TICK_CYCLES - 1);
   localparam bit            POW_2  = ((TICK_CYCLES & (TICK_CYCLES - 1)) == 0);

   logic [CW-1:0] cnt_q;

   if (TICK_CYCLES < 2) begin : g_bad_cfg
      $error("tr_tick_gen: TICK_CYCLES must be at least 2");
   end

   assign tick_o = (cnt_q == LAST);

   if (POW_2) begin : g_wrap
      // Count width matches the period, so natural overflow is the wrap
      always_ff @(posedge clk_i) begin
         if (rst_i || clr_i) cnt_q <= '0;
         else                cnt_q <= cnt_q + 1'b1;
      end
   end else begin : g_cmp
      always_ff @(posedge clk_i) begin
         if (rst_i || clr_i || tick_o) cnt_q <= '0;
         else                          cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/tr_ring_next.sv
module tr_ring_next
   import traffic_ring_pkg::*;
(
   input  lamp_vec_t cur_i,
   output lamp_vec_t nxt_o
);
   // Each bit takes the value of its lower neighbour, wrapping around:
   // red <- yellow, yellow <- green, green <- red
   for (genvar i = 0; i < LAMP_COUNT; i++) begin : g_bit
      assign nxt_o[i] = cur_i[(i + LAMP_COUNT - 1) % LAMP_COUNT];
   end
endmodule

// File: rtl/traffic_ring.sv
module traffic_ring
   import traffic_ring_pkg::*;
#(
   parameter int unsigned TICK_CYCLES = 50_000_000
) (
   input  logic       clk_i,
   input  logic       rst_i,
   output logic [2:0] lamp_o,
   output logic       illegal_o
);
   lamp_vec_t lamp_q;
   lamp_vec_t lamp_nxt;
   logic      bad_code;
   logic      tick;
   logic      flag_q;

   assign bad_code = !is_one_hot(lamp_q);

   tr_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) tick_i (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .clr_i (bad_code),
      .tick_o(tick)
   );

   tr_ring_next next_i (
      .cur_i(lamp_q),
      .nxt_o(lamp_nxt)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         lamp_q <= LAMP_RED;
         flag_q <= 1'b0;
      end else begin
         flag_q <= bad_code;
         if (bad_code)  lamp_q <= LAMP_RED;
         else if (tick) lamp_q <= lamp_nxt;
      end
   end

   assign lamp_o    = lamp_q;
   assign illegal_o = flag_q;
endmodule

// File: rtl/traffic_ring_chk.sv
module traffic_ring_chk #(
   parameter int unsigned TICK_CYCLES = 50_000_000
) (
   input logic       clk_i,
   input logic       rst_i,
   input logic [2:0] lamp_i,
   input logic       flag_i,
   input logic       tick_i
);
   // R1
   reset_red_chk: assert property (@(posedge clk_i)
      rst_i |=> (lamp_i == 3'b100) && !flag_i);

   // R5
   recover_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !$onehot(lamp_i) |=> (lamp_i == 3'b100) && flag_i);

   // R5
   flag_red_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      flag_i |-> (lamp_i == 3'b100));

   // R7
   flag_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      flag_i |=> !flag_i);

   // R3
   rotate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (tick_i && $onehot(lamp_i)) |=>
         (lamp_i == {$past(lamp_i[1]), $past(lamp_i[0]), $past(lamp_i[2])})
         || !$onehot(lamp_i));

   // R4
   tick_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      tick_i |=> !tick_i);
endmodule

bind traffic_ring traffic_ring_chk #(.TICK_CYCLES(TICK_CYCLES)) chk_i (
   .clk_i (clk_i),
   .rst_i (rst_i),
   .lamp_i(lamp_o),
   .flag_i(illegal_o),
   .tick_i(tick)
);

// File: tb/traffic_ring_tb_top.sv
`timescale 1ns/1ps
module traffic_ring_tb_top;
   localparam int unsigned N = 5;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] lamp;
   logic       flag;

   int checks = 0;
   int fails  = 0;
   int k      = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   traffic_ring #(.TICK_CYCLES(N)) dut_i (
      .clk_i    (clk),
      .rst_i    (rst),
      .lamp_o   (lamp),
      .illegal_o(flag)
   );

   function automatic logic [2:0] exp_lamp(input int edges);
      case ((edges / N) % 3)
         0:       return 3'b100;
         1:       return 3'b001;
         default: return 3'b010;
      endcase
   endfunction

   task automatic chk(input string req, input logic [2:0] el, input logic ef);
      checks++;
      if (lamp !== el || flag !== ef) begin
         fails++;
         $display("FAIL %s lamp=%b flag=%b expected lamp=%b flag=%b",
                  req, lamp, flag, el, ef);
      end
   endtask

   // R2 R3 R4 R6 R7: compare every cycle against the arithmetic model
   task automatic run(input int cycles, input string req);
      for (int c = 0; c < cycles; c++) begin
         @(posedge clk);
         k++;
         @(negedge clk);
         chk(req, exp_lamp(k), 1'b0);
      end
   endtask

   initial begin
      logic [2:0] bad_codes [5];
      bad_codes = '{3'b000, 3'b011, 3'b101, 3'b110, 3'b111};

      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", 3'b100, 1'b0);
      rst = 1'b0;
      k   = 0;

      // R3 R4: two full rotations, including the first change after reset
      run(6 * N + 2, "R3_R4");

      // R1: reset taken from a non-red lamp
      run(N, "R3_R4");
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R1", 3'b100, 1'b0);
      rst = 1'b0;
      k   = 0;
      run(3 * N, "R4");

      // R5 R6 R7: every forbidden code at varied dwell phases
      for (int i = 0; i < 5; i++) begin
         for (int ph = 0; ph < 2; ph++) begin
            run(i + ph * 2 + 1, "R2");
            force dut_i.lamp_q = bad_codes[i];
            #1;
            release dut_i.lamp_q;
            @(posedge clk);
            k = 0;
            @(negedge clk);
            chk("R5", 3'b100, 1'b1);
            run(3 * N + 1, "R6_R7");
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #4_000_000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule